// File: doc/BRIEF.md
# Smooth Digital Clock Calibrator

This block trims the effective rate of a slow timekeeping clock, nominally 32.768 kHz, before that clock reaches a calendar prescaler. Every clock cycle counts as one input pulse. The block produces a per-cycle qualifier, `pulse_en`. When it is low, the downstream prescaler skips that pulse. A second output, `pulse_extra`, makes the prescaler count two on that cycle. This is how the block inserts a pulse.

Calibration runs over a repeating window. By default the window is 2^WIN_W cycles, which is 32 s at 32768 Hz when WIN_W is 20. The window can be cut to a half or a quarter of that (16 s or 8 s).

- A minus value sets how many pulses are removed in each window. The removed pulses are spread evenly by decoding the bit-reversed upper counter bits.
- A plus bit adds a fixed 2^CAL_W pulses per full window.
- The net change per full window is therefore 512·plus − minus.

A configuration write is staged and raises a pending flag. While the flag is set, further writes are refused. The staged settings take effect on the first cycle of the next window, and the flag drops on that same edge.

Top module: `smooth_clk_cal`

## Requirements
- R1: After reset the counter is 0, the settings are minus = 0, plus = 0, full window, and the pending flag is 0. As a result, `pulse_en` is 1 and `pulse_extra` is 0 on every cycle until a new configuration takes effect.
- R2: Windows begin on the first cycle after reset. Each window lasts 2^WIN_W cycles in full mode, 2^(WIN_W-1) cycles in half mode and 2^(WIN_W-2) cycles in quarter mode. The mode used is the one in effect when the window begins.
- R3: In a full window, exactly `minus` cycles have `pulse_en` = 0. This holds for every value from 0 to 511.
- R4: Removed pulses fall only on cycles whose counter value is a multiple of S = 2^(WIN_W-CAL_W), so any two removed pulses are at least S cycles apart. With minus = 256 they are exactly 2·S apart.
- R5: With plus = 1, `pulse_extra` is high on the cycle at offset S/2 inside every S-cycle slot. This gives 2^CAL_W = 512 insertions per full window. `pulse_en` is always 1 when `pulse_extra` is 1, so the net pulse change is 512·plus − minus.
- R6: `cfg_half` = 1 selects the half window and forces minus bit 0 to 0. Each window then removes minus/2 pulses and inserts 256·plus pulses.
- R7: `cfg_quarter` = 1 selects the quarter window and forces minus bits 1:0 to 0. Each window then removes minus/4 pulses and inserts 128·plus pulses.
- R8: When `cfg_half` and `cfg_quarter` are both 1, the quarter window is used.
- R9: A `cfg_wr` strobe while `cal_pending` = 0 captures the inputs and sets `cal_pending` on the next cycle. A strobe while `cal_pending` = 1 is ignored.
- R10: `cal_pending` stays 1 through the last cycle of the current window. It reads 0 on the first cycle of the next window, which is the same cycle on which the staged settings take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; every cycle is one input pulse |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_minus | input | 9 | Pulses to remove per full window |
| cfg_plus | input | 1 | Enable insertion of 512 pulses per full window |
| cfg_half | input | 1 | Select the half-length window |
| cfg_quarter | input | 1 | Select the quarter-length window |
| cal_pending | output | 1 | Staged settings are waiting for a window boundary |
| pulse_en | output | 1 | Qualifier for the downstream prescaler; low removes a pulse |
| pulse_extra | output | 1 | Downstream prescaler counts two on this cycle |

## Verification
The two pulse outputs decode the window counter combinationally. After k clock edges since reset, or since the last boundary, they therefore describe offset k modulo the current window length. The bench tracks that offset itself and counts removed and inserted pulses over exactly one window.

`cal_pending` is due one edge after an accepted write strobe. The bench checks it on the last cycle of the window, where it must still be high, and on the first cycle of the next window, where it must be low. That second check also confirms the length of the window that has just ended.

New settings are measured only from that boundary onward. All inputs change and all outputs are read at the falling edge.

// File: rtl/smooth_cal_pkg.sv
package smooth_cal_pkg;

    // Width of the minus value; also fixes 2^CAL_W insertions per full window.
    localparam int CAL_W = 9;

    typedef enum logic [1:0] {
        WIN_FULL    = 2'd0,
        WIN_HALF    = 2'd1,
        WIN_QUARTER = 2'd2
    } win_sel_e;

    typedef struct packed {
        logic [CAL_W-1:0] minus;
        logic             plus;
        win_sel_e         win;
    } cal_cfg_t;

    localparam cal_cfg_t CFG_RESET = '{minus: '0, plus: 1'b0, win: WIN_FULL};

    // Reverse the bit order of a slot index so that consecutive ranks land far apart.
    function automatic logic [CAL_W-1:0] bit_rev(input logic [CAL_W-1:0] v);
        logic [CAL_W-1:0] r;
        for (int i = 0; i < CAL_W; i++) begin
            r[i] = v[CAL_W-1-i];
        end
        return r;
    endfunction

    // Quarter has priority when both selects are raised.
    function automatic win_sel_e pick_win(input logic half, input logic quarter);
        if (quarter) return WIN_QUARTER;
        if (half)    return WIN_HALF;
        return WIN_FULL;
    endfunction

    // Shorter windows cannot resolve the lowest minus bits.
    function automatic logic [CAL_W-1:0] trim_minus(input logic [CAL_W-1:0] m,
                                                    input win_sel_e w);
        case (w)
            WIN_HALF:    return {m[CAL_W-1:1], 1'b0};
            WIN_QUARTER: return {m[CAL_W-1:2], 2'b00};
            default:     return m;
        endcase
    endfunction

endpackage

// File: rtl/cal_window_ctr.sv
module cal_window_ctr
    import smooth_cal_pkg::*;
#(
    parameter int WIN_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  win_sel_e         win,
    output logic [WIN_W-1:0] cnt,
    output logic             win_last
);

    // A shortened window never sets the upper counter bits, so only the low part is tested.
    always_comb begin
        case (win)
            WIN_HALF:    win_last = &cnt[WIN_W-2:0];
            WIN_QUARTER: win_last = &cnt[WIN_W-3:0];
            default:     win_last = &cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (win_last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        win_last |=> (cnt == '0));

    // R2
    half_top_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (win == WIN_HALF) |-> !cnt[WIN_W-1]);

    // R2
    quarter_top_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (win == WIN_QUARTER) |-> (cnt[WIN_W-1:WIN_W-2] == 2'b00));

endmodule

// File: rtl/cal_cfg_stage.sv
module cal_cfg_stage
    import smooth_cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CAL_W-1:0] cfg_minus,
    input  logic             cfg_plus,
    input  logic             cfg_half,
    input  logic             cfg_quarter,
    input  logic             win_last,
    output cal_cfg_t         active,
    output logic             pending
);

    cal_cfg_t staged;
    win_sel_e req_win;

    always_comb begin
        req_win = pick_win(cfg_half, cfg_quarter);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= CFG_RESET;
            staged  <= CFG_RESET;
            pending <= 1'b0;
        end else if (cfg_wr && !pending) begin
            staged.minus <= trim_minus(cfg_minus, req_win);
            staged.plus  <= cfg_plus;
            staged.win   <= req_win;
            pending      <= 1'b1;
        end else if (pending && win_last) begin
            active  <= staged;
            pending <= 1'b0;
        end
    end

    // R9
    stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pending && !win_last) |=> ($stable(staged) && pending));

    // R10
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pending) |-> $past(win_last));

    // R10
    apply_on_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !$fell(pending) |-> $stable(active));

    // R6
    half_trim_chk: assert property (@(posedge clk) disable iff (rst)
        (active.win == WIN_HALF) |-> !active.minus[0]);

    // R7
    quarter_trim_chk: assert property (@(posedge clk) disable iff (rst)
        (active.win == WIN_QUARTER) |-> (active.minus[1:0] == 2'b00));

endmodule

// File: rtl/cal_pulse_shaper.sv
module cal_pulse_shaper
    import smooth_cal_pkg::*;
#(
    parameter int WIN_W = 20
) (
    input  logic [WIN_W-1:0] cnt,
    input  cal_cfg_t         active,
    output logic             pulse_en,
    output logic             pulse_extra
);

    localparam int SLOT_W = WIN_W - CAL_W;
    localparam logic [SLOT_W-1:0] INS_POS = SLOT_W'(1) << (SLOT_W - 1);

    logic             slot_head;
    logic             slot_mid;
    logic [CAL_W-1:0] rank;
    logic             drop;

    always_comb begin
        slot_head   = (cnt[SLOT_W-1:0] == '0);
        slot_mid    = (cnt[SLOT_W-1:0] == INS_POS);
        rank        = bit_rev(cnt[WIN_W-1 -: CAL_W]);
        drop        = slot_head && (rank < active.minus);
        pulse_en    = !drop;
        pulse_extra = active.plus && slot_mid;
    end

endmodule

// File: rtl/smooth_clk_cal.sv
module smooth_clk_cal
    import smooth_cal_pkg::*;
#(
    parameter int WIN_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CAL_W-1:0] cfg_minus,
    input  logic             cfg_plus,
    input  logic             cfg_half,
    input  logic             cfg_quarter,
    output logic             cal_pending,
    output logic             pulse_en,
    output logic             pulse_extra
);

    logic [WIN_W-1:0] cnt;
    logic             win_last;
    cal_cfg_t         active;

    cal_window_ctr #(.WIN_W(WIN_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .win      (active.win),
        .cnt      (cnt),
        .win_last (win_last)
    );

    cal_cfg_stage u_cfg (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr      (cfg_wr),
        .cfg_minus   (cfg_minus),
        .cfg_plus    (cfg_plus),
        .cfg_half    (cfg_half),
        .cfg_quarter (cfg_quarter),
        .win_last    (win_last),
        .active      (active),
        .pending     (cal_pending)
    );

    cal_pulse_shaper #(.WIN_W(WIN_W)) u_shape (
        .cnt         (cnt),
        .active      (active),
        .pulse_en    (pulse_en),
        .pulse_extra (pulse_extra)
    );

    // R5
    extra_keeps_en_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_extra |-> pulse_en);

    // R4
    drop_not_adjacent_chk: assert property (@(posedge clk) disable iff (rst)
        !pulse_en |=> pulse_en);

    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !rst) |-> (pulse_en && !pulse_extra && !cal_pending));

endmodule

// File: tb/tb_smooth_clk_cal.sv
module tb_smooth_clk_cal;

    localparam int CLK_PERIOD = 10;
    localparam int WIN_W      = 12;
    localparam int FULL_LEN   = 1 << WIN_W;
    localparam int SLOT       = 1 << (WIN_W - 9);

    logic       clk;
    logic       rst;
    logic       cfg_wr;
    logic [8:0] cfg_minus;
    logic       cfg_plus;
    logic       cfg_half;
    logic       cfg_quarter;
    logic       cal_pending;
    logic       pulse_en;
    logic       pulse_extra;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int base   = 0;
    int cur_len = FULL_LEN;

    smooth_clk_cal #(.WIN_W(WIN_W)) dut (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr      (cfg_wr),
        .cfg_minus   (cfg_minus),
        .cfg_plus    (cfg_plus),
        .cfg_half    (cfg_half),
        .cfg_quarter (cfg_quarter),
        .cal_pending (cal_pending),
        .pulse_en    (pulse_en),
        .pulse_extra (pulse_extra)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cyc++;
    endtask

    task automatic write_cfg(input int m, input int p, input int h, input int q);
        cfg_wr      = 1'b1;
        cfg_minus   = 9'(m);
        cfg_plus    = 1'(p);
        cfg_half    = 1'(h);
        cfg_quarter = 1'(q);
        step();
        cfg_wr      = 1'b0;
        chk("R9", "pending after write", int'(cal_pending), 1);
    endtask

    // Runs up to the next window start; the new window length applies from there.
    task automatic run_to_boundary(input int new_len);
        while (((cyc - base) % cur_len) != 0) begin
            if (((cyc - base) % cur_len) == cur_len - 1)
                chk("R10", "pending on last window cycle", int'(cal_pending), 1);
            step();
        end
        chk("R10", "pending at new window start", int'(cal_pending), 0);
        base    = cyc;
        cur_len = new_len;
    endtask

    task automatic count_window(output int masked, output int extras, output int min_gap,
                                output int max_gap, output int first_pos, output int clash);
        int last;
        masked = 0; extras = 0; min_gap = 1 << 30; max_gap = 0;
        first_pos = -1; clash = 0; last = -1;
        for (int i = 0; i < cur_len; i++) begin
            if (!pulse_en) begin
                if (last >= 0) begin
                    if (i - last < min_gap) min_gap = i - last;
                    if (i - last > max_gap) max_gap = i - last;
                end else begin
                    first_pos = i;
                end
                last = i;
                masked++;
            end
            if (pulse_extra) begin
                extras++;
                if (!pulse_en) clash++;
            end
            step();
        end
    endtask

    task automatic t_reset();
        int mk, ex, mn, mx, fp, cl;
        chk("R1", "pending after reset", int'(cal_pending), 0);
        chk("R1", "pulse_en after reset", int'(pulse_en), 1);
        chk("R1", "pulse_extra after reset", int'(pulse_extra), 0);
        count_window(mk, ex, mn, mx, fp, cl);
        chk("R1", "removed in idle window", mk, 0);
        chk("R1", "inserted in idle window", ex, 0);
    endtask

    task automatic t_minus77();
        int mk, ex, mn, mx, fp, cl;
        write_cfg(77, 0, 0, 0);
        run_to_boundary(FULL_LEN);
        count_window(mk, ex, mn, mx, fp, cl);
        chk("R3", "removed with minus 77", mk, 77);
        chk("R4", "min gap >= slot with minus 77", int'(mn >= SLOT), 1);
        chk("R2", "first removal at window start", fp, 0);
        chk("R5", "no insertion with plus 0", ex, 0);
    endtask

    task automatic t_minus256();
        int mk, ex, mn, mx, fp, cl;
        write_cfg(256, 0, 0, 0);
        run_to_boundary(FULL_LEN);
        count_window(mk, ex, mn, mx, fp, cl);
        chk("R3", "removed with minus 256", mk, 256);
        chk("R4", "min gap with minus 256", mn, 2 * SLOT);
        chk("R4", "max gap with minus 256", mx, 2 * SLOT);
    endtask

    task automatic t_plus();
        int mk, ex, mn, mx, fp, cl;
        write_cfg(100, 1, 0, 0);
        run_to_boundary(FULL_LEN);
        count_window(mk, ex, mn, mx, fp, cl);
        chk("R3", "removed with plus set", mk, 100);
        chk("R5", "insertions per full window", ex, 512);
        chk("R5", "insert while qualifier low", cl, 0);
        chk("R5", "net pulse change", ex - mk, 412);
    endtask

    task automatic t_pending_block();
        int mk, ex, mn, mx, fp, cl;
        write_cfg(5, 0, 0, 0);
        write_cfg(300, 1, 1, 0);
        run_to_boundary(FULL_LEN);
        count_window(mk, ex, mn, mx, fp, cl);
        chk("R9", "second write ignored, removed", mk, 5);
        chk("R9", "second write ignored, inserted", ex, 0);
    endtask

    task automatic t_half();
        int mk, ex, mn, mx, fp, cl;
        write_cfg(101, 0, 1, 0);
        run_to_boundary(FULL_LEN / 2);
        count_window(mk, ex, mn, mx, fp, cl);
        chk("R6", "removed in half window, minus 101", mk, 50);
        chk("R6", "inserted in half window, plus 0", ex, 0);
    endtask

    task automatic t_quarter();
        int mk, ex, mn, mx, fp, cl;
        write_cfg(103, 1, 0, 1);
        run_to_boundary(FULL_LEN / 4);
        count_window(mk, ex, mn, mx, fp, cl);
        chk("R7", "removed in quarter window, minus 103", mk, 25);
        chk("R7", "inserted in quarter window", ex, 128);
    endtask

    task automatic t_both();
        int mk, ex, mn, mx, fp, cl;
        write_cfg(7, 1, 1, 1);
        run_to_boundary(FULL_LEN / 4);
        count_window(mk, ex, mn, mx, fp, cl);
        chk("R8", "both selects, removed", mk, 1);
        chk("R8", "both selects, inserted", ex, 128);
    endtask

    task automatic t_max();
        int mk, ex, mn, mx, fp, cl;
        write_cfg(511, 0, 0, 0);
        run_to_boundary(FULL_LEN);
        count_window(mk, ex, mn, mx, fp, cl);
        chk("R3", "removed with minus 511", mk, 511);
        chk("R4", "min gap >= slot with minus 511", int'(mn >= SLOT), 1);
        chk("R2", "full window restored, insertions", ex, 0);
    endtask

    initial begin
        rst = 1'b1;
        cfg_wr = 1'b0; cfg_minus = '0; cfg_plus = 1'b0;
        cfg_half = 1'b0; cfg_quarter = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0; base = 0; cur_len = FULL_LEN;
        t_reset();
        t_minus77();
        t_minus256();
        t_plus();
        t_pending_block();
        t_half();
        t_quarter();
        t_both();
        t_max();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual %0d expected %0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule